// File: doc/BRIEF.md
# Host Strobe Ready Timer

This block produces the active-low busy/ready indication that a speech processor presents to its host bus. The host talks to the processor through two separate active-low strobes, one for reads and one for writes. When either strobe falls, the ready output goes inactive at once and stays inactive for a number of processor clocks before it is released. The length of that hold depends on which strobe fired and, for writes, on whether the processor is in speak-external mode and on which command the write carries.

Both strobes come from the host side and are brought into the clock domain through a synchronizer chain. Falling edges are found on the synchronized copies. A fresh falling edge that arrives while the output is already inactive restarts the hold with the duration chosen for the new access. Rising strobe edges do nothing. The mode flag and the decoded command are sampled in the cycle in which the falling edge is seen.

Top module: `srt_ready_timer`

## Requirements
- R1: A falling edge on `rd_stb_n` or `wr_stb_n` makes `ready_n` go to 1 (inactive) after exactly SYNC_STAGES rising clock edges (two with the default configuration).
- R2: After a read-strobe falling edge, `ready_n` stays at 1 for exactly RD_HOLD cycles (default 16) and then returns to 0.
- R3: After a write-strobe falling edge with `ext_mode` = 1, `ready_n` stays at 1 for exactly EXT_HOLD cycles (default 16), whatever the value of `cmd_code`.
- R4: After a write-strobe falling edge with `ext_mode` = 0 and `cmd_code` equal to 3'd1 (read-busy) or 3'd7 (soft reset), `ready_n` stays at 1 for exactly LONG_HOLD cycles (default 140).
- R5: After a write-strobe falling edge with `ext_mode` = 0 and `cmd_code` equal to 3'd2 (read-byte), `ready_n` stays at 1 for exactly BYTE_HOLD cycles (default 80).
- R6: After a write-strobe falling edge with `ext_mode` = 0 and any other `cmd_code` (3'd0, 3'd3, 3'd4, 3'd5, 3'd6), `ready_n` stays at 1 for exactly SHORT_HOLD cycles (default 16).
- R7: When both strobes fall in the same cycle, the write rule (R3 to R6) sets the hold length.
- R8: A falling edge detected while `ready_n` is already 1 restarts the hold: `ready_n` stays at 1 without a gap until the new access's hold length has passed from the new edge.
- R9: A rising edge on either strobe has no effect on `ready_n`.
- R10: While `rst_n` is 0 and right after it is released, `ready_n` is 0; asserting reset during a hold ends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb_n | input | 1 | Host read strobe, active low, asynchronous |
| wr_stb_n | input | 1 | Host write strobe, active low, asynchronous |
| ext_mode | input | 1 | 1 when the processor is in speak-external mode |
| cmd_code | input | 3 | Decoded command carried by the current write |
| ready_n | output | 1 | Ready to host, active low (1 = busy) |

## Verification
A wrong hold count in the down-counter shows at the ports as a busy window that is too long or too short, visible on the very access that loaded it, so each mode and command is driven and the exact run length of `ready_n` is measured. A synchronizer or edge-detector fault shows as the wrong latency from strobe fall to `ready_n` rising, or as a spurious busy window after a strobe rises, both within a few cycles. A restart fault shows as a gap in `ready_n` or as the first access's length instead of the second's.

// File: rtl/srt_pkg.sv
package srt_pkg;
   localparam int CMD_W = 3;

   typedef enum logic [CMD_W-1:0] {
      CMD_OTHER0    = 3'd0,
      CMD_READ_BUSY = 3'd1,
      CMD_READ_BYTE = 3'd2,
      CMD_OTHER3    = 3'd3,
      CMD_OTHER4    = 3'd4,
      CMD_OTHER5    = 3'd5,
      CMD_OTHER6    = 3'd6,
      CMD_SOFT_RST  = 3'd7
   } cmd_e;

   typedef enum logic [1:0] {
      HOLD_SHORT = 2'd0,
      HOLD_BYTE  = 2'd1,
      HOLD_LONG  = 2'd2
   } hold_class_e;

   function automatic hold_class_e classify_cmd(input logic [CMD_W-1:0] code);
      hold_class_e c;
      case (code)
         CMD_READ_BUSY, CMD_SOFT_RST: c = HOLD_LONG;
         CMD_READ_BYTE:               c = HOLD_BYTE;
         default:                     c = HOLD_SHORT;
      endcase
      return c;
   endfunction
endpackage

// File: rtl/srt_strobe_sync.sv
module srt_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_n,
   output logic fall
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("srt_strobe_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b1;
      else        chain[0] <= strobe_n;
   end

   genvar gi;
   generate
      for (gi = 1; gi < STAGES; gi++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[gi] <= 1'b1;
            else        chain[gi] <= chain[gi-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b1;
      else        last_q <= chain[STAGES-1];
   end

   assign fall = last_q & ~chain[STAGES-1];

   // R9: a fall pulse never lasts two cycles, so a held or rising strobe makes none
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);
endmodule

// File: rtl/srt_hold_select.sv
module srt_hold_select
   import srt_pkg::*;
#(
   parameter int RD_HOLD    = 16,
   parameter int EXT_HOLD   = 16,
   parameter int SHORT_HOLD = 16,
   parameter int BYTE_HOLD  = 80,
   parameter int LONG_HOLD  = 140,
   parameter int CNT_W      = 8
) (
   input  logic             rd_fall,
   input  logic             wr_fall,
   input  logic             ext_mode,
   input  logic [CMD_W-1:0] cmd_code,
   output logic             load,
   output logic [CNT_W-1:0] load_val
);
   localparam logic [CNT_W-1:0] RD_VAL    = CNT_W'(RD_HOLD - 1);
   localparam logic [CNT_W-1:0] EXT_VAL   = CNT_W'(EXT_HOLD - 1);
   localparam logic [CNT_W-1:0] SHORT_VAL = CNT_W'(SHORT_HOLD - 1);
   localparam logic [CNT_W-1:0] BYTE_VAL  = CNT_W'(BYTE_HOLD - 1);
   localparam logic [CNT_W-1:0] LONG_VAL  = CNT_W'(LONG_HOLD - 1);

   logic [CNT_W-1:0] wr_val;
   hold_class_e      wr_class;

   assign wr_class = classify_cmd(cmd_code);

   always_comb begin
      if (ext_mode) begin
         wr_val = EXT_VAL;
      end else begin
         case (wr_class)
            HOLD_LONG: wr_val = LONG_VAL;
            HOLD_BYTE: wr_val = BYTE_VAL;
            default:   wr_val = SHORT_VAL;
         endcase
      end
   end

   assign load     = rd_fall | wr_fall;
   assign load_val = wr_fall ? wr_val : RD_VAL;
endmodule

// File: rtl/srt_hold_counter.sv
module srt_hold_counter #(
   parameter int CNT_W    = 8,
   parameter int MAX_LOAD = 139
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             busy
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          count <= '0;
      else if (load)       count <= load_val;
      else if (count != 0) count <= count - 1'b1;
   end

   assign busy = (count != '0);

   // R8: without a new edge the counter only walks down by one
   a_r8_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && busy) |=> (count == $past(count) - 1'b1));

   // R4: no hold exceeds the longest configured one
   a_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(MAX_LOAD));
endmodule

// File: rtl/srt_ready_timer.sv
module srt_ready_timer
   import srt_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int RD_HOLD     = 16,
   parameter int EXT_HOLD    = 16,
   parameter int SHORT_HOLD  = 16,
   parameter int BYTE_HOLD   = 80,
   parameter int LONG_HOLD   = 140
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_stb_n,
   input  logic             wr_stb_n,
   input  logic             ext_mode,
   input  logic [CMD_W-1:0] cmd_code,
   output logic             ready_n
);
   localparam int MAX_A    = (RD_HOLD > EXT_HOLD) ? RD_HOLD : EXT_HOLD;
   localparam int MAX_B    = (SHORT_HOLD > BYTE_HOLD) ? SHORT_HOLD : BYTE_HOLD;
   localparam int MAX_C    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int MAX_HOLD = (MAX_C > LONG_HOLD) ? MAX_C : LONG_HOLD;
   localparam int CNT_W    = $clog2(MAX_HOLD + 1);

   generate
      if (RD_HOLD < 1 || EXT_HOLD < 1 || SHORT_HOLD < 1 ||
          BYTE_HOLD < 1 || LONG_HOLD < 1) begin : g_bad_hold
         $error("srt_ready_timer: every hold length must be at least 1");
      end
   endgenerate

   logic             rd_fall, wr_fall, load, busy;
   logic [CNT_W-1:0] load_val, count;

   srt_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
      .clk(clk), .rst_n(rst_n), .strobe_n(rd_stb_n), .fall(rd_fall));

   srt_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
      .clk(clk), .rst_n(rst_n), .strobe_n(wr_stb_n), .fall(wr_fall));

   srt_hold_select #(
      .RD_HOLD(RD_HOLD), .EXT_HOLD(EXT_HOLD), .SHORT_HOLD(SHORT_HOLD),
      .BYTE_HOLD(BYTE_HOLD), .LONG_HOLD(LONG_HOLD), .CNT_W(CNT_W)
   ) u_sel (
      .rd_fall(rd_fall), .wr_fall(wr_fall), .ext_mode(ext_mode),
      .cmd_code(cmd_code), .load(load), .load_val(load_val));

   srt_hold_counter #(.CNT_W(CNT_W), .MAX_LOAD(MAX_HOLD - 1)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
      .count(count), .busy(busy));

   // the detection cycle itself is the first busy cycle
   assign ready_n = busy | load;

   // R1: a detected edge shows at the output in the same cycle
   a_r1_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fall || wr_fall) |-> ready_n);

   // R2: a lone read edge loads the read hold
   a_r2_read_load: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fall && !wr_fall) |=> (count == CNT_W'(RD_HOLD - 1)));

   // R3: a write in speak-external mode loads the external hold
   a_r3_ext_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fall && ext_mode) |=> (count == CNT_W'(EXT_HOLD - 1)));

   // R9: ready never goes busy without a detected edge
   a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_fall && !wr_fall && $past(!ready_n)) |-> !ready_n);
endmodule

// File: tb/srt_ready_timer_test.sv
module srt_ready_timer_test;
   localparam int RD_H = 16, EXT_H = 16, SH_H = 16, BY_H = 80, LG_H = 140;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rd_stb_n = 1'b1, wr_stb_n = 1'b1, ext_mode = 1'b0;
   logic [2:0] cmd_code = 3'd0;
   logic       ready_n;

   int n_checks = 0, n_fail = 0;

   always #10 clk = ~clk;

   srt_ready_timer #(.SYNC_STAGES(2), .RD_HOLD(RD_H), .EXT_HOLD(EXT_H),
      .SHORT_HOLD(SH_H), .BYTE_HOLD(BY_H), .LONG_HOLD(LG_H)) uut (
      .clk(clk), .rst_n(rst_n), .rd_stb_n(rd_stb_n), .wr_stb_n(wr_stb_n),
      .ext_mode(ext_mode), .cmd_code(cmd_code), .ready_n(ready_n));

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int write_hold(input logic ext, input logic [2:0] c);
      if (ext) return EXT_H;
      if (c == 3'd1 || c == 3'd7) return LG_H;
      if (c == 3'd2) return BY_H;
      return SH_H;
   endfunction

   // drives one access (rd/wr chosen by flags), optional second edge after gap2
   task automatic access(input logic do_rd, input logic do_wr, input logic ext,
                         input logic [2:0] c, input int gap2, input logic rd2,
                         output int latency, output int run);
      int first_hi = -1;
      run = 0;
      @(negedge clk);
      ext_mode = ext; cmd_code = c;
      if (do_rd) rd_stb_n = 1'b0;
      if (do_wr) wr_stb_n = 1'b0;
      for (int i = 1; i < 400; i++) begin
         @(negedge clk);
         if (i == 3) begin rd_stb_n = 1'b1; wr_stb_n = 1'b1; end
         if (gap2 > 0 && i == gap2) begin
            if (rd2) rd_stb_n = 1'b0; else wr_stb_n = 1'b0;
         end
         if (gap2 > 0 && i == gap2 + 3) begin rd_stb_n = 1'b1; wr_stb_n = 1'b1; end
         if (ready_n && first_hi < 0) first_hi = i;
         if (ready_n) run++;
         if (!ready_n && first_hi >= 0) break;
      end
      latency = first_hi;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(200000 * 20);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      int lat, run, idle_busy;
      repeat (3) @(negedge clk);
      check("R10 ready_n during reset", int'(ready_n), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 ready_n after reset", int'(ready_n), 0);

      // R2 read hold, independent of mode and command
      for (int m = 0; m < 2; m++) begin
         access(1'b1, 1'b0, m[0], 3'd1, 0, 1'b0, lat, run);
         check("R1 read latency", lat, 2);
         check("R2 read hold", run, RD_H);
      end

      // R3..R6 sweep every command in both modes
      for (int m = 0; m < 2; m++) begin
         for (int c = 0; c < 8; c++) begin
            access(1'b0, 1'b1, m[0], c[2:0], 0, 1'b0, lat, run);
            check("R1 write latency", lat, 2);
            if (m == 1) check("R3 ext-mode write hold", run, write_hold(1'b1, c[2:0]));
            else if (c == 1 || c == 7) check("R4 long command hold", run, LG_H);
            else if (c == 2) check("R5 read-byte hold", run, BY_H);
            else check("R6 short command hold", run, SH_H);
         end
      end

      // R7 simultaneous strobes follow the write rule
      access(1'b1, 1'b1, 1'b0, 3'd2, 0, 1'b0, lat, run);
      check("R7 both strobes, read-byte", run, BY_H);
      access(1'b1, 1'b1, 1'b0, 3'd7, 0, 1'b0, lat, run);
      check("R7 both strobes, soft reset", run, LG_H);

      // R8 restart: long write then read edge 10 cycles later
      access(1'b0, 1'b1, 1'b0, 3'd1, 10, 1'b1, lat, run);
      check("R8 restart long->read", run, 10 + RD_H);
      // R8 restart: short read then long write 8 cycles later
      access(1'b1, 1'b0, 1'b0, 3'd7, 8, 1'b0, lat, run);
      check("R8 restart read->long", run, 8 + LG_H);

      // R9 rising edges: hold strobe low past the hold, then release
      @(negedge clk);
      ext_mode = 1'b1; rd_stb_n = 1'b0;
      repeat (RD_H + 10) @(negedge clk);
      check("R9 idle with strobe held low", int'(ready_n), 0);
      rd_stb_n = 1'b1; wr_stb_n = 1'b1;
      idle_busy = 0;
      repeat (12) begin
         @(negedge clk);
         if (ready_n) idle_busy++;
      end
      check("R9 busy cycles after rising strobe", idle_busy, 0);

      // R10 reset aborts a hold
      @(negedge clk);
      ext_mode = 1'b0; cmd_code = 3'd1; wr_stb_n = 1'b0;
      repeat (6) @(negedge clk);
      check("R10 busy before reset", int'(ready_n), 1);
      wr_stb_n = 1'b1;
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 ready_n in reset during hold", int'(ready_n), 0);
      rst_n = 1'b1;
      idle_busy = 0;
      repeat (20) begin
         @(negedge clk);
         if (ready_n) idle_busy++;
      end
      check("R10 busy cycles after reset", idle_busy, 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule